// File: doc/BRIEF.md
# Aligned Transfer Segmentation Planner

This block turns a single byte-transfer request into an ordered series of segment commands for a downstream bus engine. A request carries a start address, a byte length and a flag that bars burst transfers. Each segment the block emits is one of two kinds. An immediate piece moves 1, 2 or 4 bytes. A burst piece moves a multiple of 32 bytes. Each segment carries its own address and length, so the engine can run it without any further arithmetic.

For a request of 32 bytes or more with bursts allowed, the block splits the range at 32-byte boundaries. The unaligned bytes before the first boundary form the head. Whole 32-byte blocks form the middle. The bytes after the last boundary form the tail. The head and tail go out as immediate pieces and the middle goes out as a single burst. Some requests are long enough but contain no whole aligned block. For these, the block emits one 32-byte burst starting at the request address, flagged so that the engine stages it through an aligned bounce buffer. The remaining bytes follow as immediate pieces.

The request port and the segment port both use valid/ready handshakes. The block takes one request at a time.

Top module: `seg_planner`

## Requirements
- R1: After reset, segValid is 0 and reqReady is 1.
- R2: When reqLen is below 32 or reqNoBurst is 1, every segment of the request is immediate (segBurst=0) and the pieces cover the range in ascending address order.
- R3: The bytes of an immediate run go out as 4-byte pieces. A final remainder of 3 bytes goes out as a 2-byte piece followed by a 1-byte piece. A remainder of 1 or 2 bytes goes out as one piece of that size.
- R4: With bursts allowed and reqLen of 32 or more, the head length is (32 - reqAddr mod 32) mod 32. A non-empty aligned middle goes out as one burst (segBurst=1, segBounce=0) whose address has its low 5 bits zero and whose length is a nonzero multiple of 32.
- R5: The tail length is (reqAddr + reqLen) mod 32, and the tail goes out as immediate pieces starting at the last 32-byte boundary of the range.
- R6: With bursts allowed, reqLen of 32 or more and an empty aligned middle, the block first emits a burst with segBounce=1, length 32 and address reqAddr. The remaining reqLen-32 bytes follow as immediate pieces starting at reqAddr+32.
- R7: Segments go out in this order: head pieces, then the burst, then tail pieces. Each segment's address equals the previous segment's address plus its length, taken modulo 2^32.
- R8: A request with reqLen 0 is accepted and produces no segments. reqReady stays 1 afterwards.
- R9: segLast is 1 on the final segment of a request and 0 on every other segment.
- R10: reqReady is 0 from the acceptance of a non-empty request until its last segment is consumed. reqReady and segValid are never 1 together.
- R11: While segValid is 1 and segReady is 0, the segment fields hold steady into the next cycle.
- R12: A range that crosses the top of the address space is split the same way, with addresses wrapping modulo 2^32 and lengths unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block can accept a request |
| reqAddr | input | 32 | Start byte address |
| reqLen | input | 16 | Byte count |
| reqNoBurst | input | 1 | 1 forces immediate pieces only |
| segValid | output | 1 | Segment offered |
| segReady | input | 1 | Consumer takes the segment |
| segBurst | output | 1 | 1 = burst piece, 0 = immediate piece |
| segBounce | output | 1 | Burst staged through the aligned bounce buffer |
| segAddr | output | 32 | Segment start address |
| segLen | output | 16 | Segment byte count |
| segLast | output | 1 | Final segment of the request |

## Verification
Several properties are checked on every cycle: that immediate pieces only ever have lengths of 1, 2 or 4; that plain bursts are aligned multiples of 32; that bounce bursts are exactly 32 bytes; that no burst appears for a barred or short request; that addresses stay contiguous across a request; that a stalled segment is held; and that the two ports stay exclusive. Other behaviours can only be shown by the bench's scenarios, which compare whole segment lists against an independently computed expectation. These are the exact head and tail lengths, the choice between a split and a bounce merge, the 2-then-1 ordering of a 3-byte remainder, the position of the last flag, wrap-around at the top of the address space, and the handling of zero-length requests.

// File: rtl/seg_pkg.sv
package seg_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } ctrlState_e;

  typedef struct packed {
    logic load;
    logic advance;
  } segStrobe_t;
endpackage

// File: rtl/seg_ctrl.sv
module seg_ctrl
  import seg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqEmpty,
  input  logic       segReady,
  input  logic       lastSeg,
  output logic       reqReady,
  output logic       segValid,
  output segStrobe_t strobe
);
  ctrlState_e state, stateNext;

  always_comb begin
    stateNext      = state;
    strobe.load    = 1'b0;
    strobe.advance = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid && !reqEmpty) begin
          strobe.load = 1'b1;
          stateNext   = ST_RUN;
        end
      end
      ST_RUN: begin
        if (segReady) begin
          strobe.advance = 1'b1;
          if (lastSeg) stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign reqReady = (state == ST_IDLE);
  assign segValid = (state == ST_RUN);
endmodule

// File: rtl/seg_dp.sv
module seg_dp
  import seg_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int BLK_BYTES = 32,
  parameter int PIECE_MAX = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  segStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              reqNoBurst,
  output logic              reqEmpty,
  output logic              segBurst,
  output logic              segBounce,
  output logic [ADDR_W-1:0] segAddr,
  output logic [LEN_W-1:0]  segLen,
  output logic              lastSeg
);
  localparam int OFS_W     = $clog2(BLK_BYTES);
  localparam int PIECE_LOG = $clog2(PIECE_MAX);
  localparam logic [LEN_W-1:0] BLK_LEN = LEN_W'(BLK_BYTES);

  // Request decode, evaluated in the accept cycle
  logic [OFS_W-1:0] startOfs, headOfs, tailOfs;
  logic [LEN_W-1:0] headLen, tailLen, midLen;
  logic             useBurst, useBounce;

  always_comb begin
    startOfs  = reqAddr[OFS_W-1:0];
    headOfs   = OFS_W'(~startOfs + 1'b1);
    tailOfs   = startOfs + reqLen[OFS_W-1:0];
    headLen   = LEN_W'(headOfs);
    tailLen   = LEN_W'(tailOfs);
    useBurst  = !reqNoBurst && (reqLen >= BLK_LEN);
    midLen    = reqLen - headLen - tailLen;
    useBounce = useBurst && (midLen == '0);
  end

  assign reqEmpty = (reqLen == '0);

  // Per-phase remaining counters
  logic [ADDR_W-1:0] curAddr;
  logic [LEN_W-1:0]  remHead, remMid, remTail;
  logic              bounceHeld;

  logic              inHead, inMid;
  logic [LEN_W-1:0]  curRem, pieceLen;

  function automatic logic [LEN_W-1:0] pieceFor(input logic [LEN_W-1:0] rem);
    logic [LEN_W-1:0] r;
    r = LEN_W'(1);
    for (int k = 0; k <= PIECE_LOG; k++) begin
      if (LEN_W'(1 << k) <= rem) r = LEN_W'(1 << k);
    end
    return r;
  endfunction

  always_comb begin
    inHead   = (remHead != '0);
    inMid    = !inHead && (remMid != '0);
    curRem   = inHead ? remHead : (inMid ? remMid : remTail);
    pieceLen = pieceFor(curRem);
    segLen   = inMid ? remMid : pieceLen;
    segBurst = inMid;
    segBounce = inMid && bounceHeld;
    segAddr  = curAddr;
    if (segLen != curRem)  lastSeg = 1'b0;
    else if (inHead)       lastSeg = (remMid == '0) && (remTail == '0);
    else if (inMid)        lastSeg = (remTail == '0);
    else                   lastSeg = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr    <= '0;
      remHead    <= '0;
      remMid     <= '0;
      remTail    <= '0;
      bounceHeld <= 1'b0;
    end else if (strobe.load) begin
      curAddr <= reqAddr;
      if (!useBurst) begin
        remHead    <= reqLen;
        remMid     <= '0;
        remTail    <= '0;
        bounceHeld <= 1'b0;
      end else if (useBounce) begin
        remHead    <= '0;
        remMid     <= BLK_LEN;
        remTail    <= reqLen - BLK_LEN;
        bounceHeld <= 1'b1;
      end else begin
        remHead    <= headLen;
        remMid     <= midLen;
        remTail    <= tailLen;
        bounceHeld <= 1'b0;
      end
    end else if (strobe.advance) begin
      curAddr <= curAddr + ADDR_W'(segLen);
      if (inHead) begin
        remHead <= remHead - segLen;
      end else if (inMid) begin
        remMid     <= '0;
        bounceHeld <= 1'b0;
      end else begin
        remTail <= remTail - segLen;
      end
    end
  end
endmodule

// File: rtl/seg_planner.sv
module seg_planner
  import seg_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int BLK_BYTES = 32,
  parameter int PIECE_MAX = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              reqNoBurst,
  output logic              segValid,
  input  logic              segReady,
  output logic              segBurst,
  output logic              segBounce,
  output logic [ADDR_W-1:0] segAddr,
  output logic [LEN_W-1:0]  segLen,
  output logic              segLast
);
  segStrobe_t strobe;
  logic       reqEmpty;
  logic       lastSeg;

  seg_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqEmpty (reqEmpty),
    .segReady (segReady),
    .lastSeg  (lastSeg),
    .reqReady (reqReady),
    .segValid (segValid),
    .strobe   (strobe)
  );

  seg_dp #(
    .ADDR_W    (ADDR_W),
    .LEN_W     (LEN_W),
    .BLK_BYTES (BLK_BYTES),
    .PIECE_MAX (PIECE_MAX)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqAddr    (reqAddr),
    .reqLen     (reqLen),
    .reqNoBurst (reqNoBurst),
    .reqEmpty   (reqEmpty),
    .segBurst   (segBurst),
    .segBounce  (segBounce),
    .segAddr    (segAddr),
    .segLen     (segLen),
    .lastSeg    (lastSeg)
  );

  assign segLast = lastSeg;
endmodule

// File: rtl/seg_planner_chk.sv
module seg_planner_chk #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int BLK_BYTES = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [LEN_W-1:0]  reqLen,
  input logic              reqNoBurst,
  input logic              segValid,
  input logic              segReady,
  input logic              segBurst,
  input logic              segBounce,
  input logic [ADDR_W-1:0] segAddr,
  input logic [LEN_W-1:0]  segLen,
  input logic              segLast
);
  localparam int OFS_W = $clog2(BLK_BYTES);

  logic              allowBurst;
  logic              firstSeg;
  logic [ADDR_W-1:0] nextAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      allowBurst <= 1'b0;
      firstSeg   <= 1'b1;
      nextAddr   <= '0;
    end else begin
      if (reqValid && reqReady) begin
        allowBurst <= !reqNoBurst && (reqLen >= LEN_W'(BLK_BYTES));
        firstSeg   <= 1'b1;
      end else if (segValid && segReady) begin
        firstSeg <= segLast;
        nextAddr <= segAddr + ADDR_W'(segLen);
      end
    end
  end

  // R2: bursts only for requests that permit them
  a_r2_burst_permitted: assert property (@(posedge clk) disable iff (!rstN)
    segValid && segBurst |-> allowBurst);

  // R3: immediate piece sizes
  a_r3_piece_size: assert property (@(posedge clk) disable iff (!rstN)
    segValid && !segBurst |-> (segLen == LEN_W'(1) || segLen == LEN_W'(2) || segLen == LEN_W'(4)));

  // R4: plain bursts aligned and block-sized
  a_r4_mid_aligned: assert property (@(posedge clk) disable iff (!rstN)
    segValid && segBurst && !segBounce |->
      (segAddr[OFS_W-1:0] == '0) && (segLen[OFS_W-1:0] == '0) && (segLen != '0));

  // R6: bounce burst shape
  a_r6_bounce_shape: assert property (@(posedge clk) disable iff (!rstN)
    segValid && segBounce |-> segBurst && (segLen == LEN_W'(BLK_BYTES)));

  // R7: contiguous addresses within a request
  a_r7_contiguous: assert property (@(posedge clk) disable iff (!rstN)
    segValid && !firstSeg |-> segAddr == nextAddr);

  // R10: one request in flight
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(reqReady && segValid));

  // R11: stalled segment held
  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    segValid && !segReady |=> segValid && $stable(segAddr) && $stable(segLen)
      && $stable(segBurst) && $stable(segBounce) && $stable(segLast));
endmodule

bind seg_planner seg_planner_chk #(
  .ADDR_W    (ADDR_W),
  .LEN_W     (LEN_W),
  .BLK_BYTES (BLK_BYTES)
) u_chk (.*);

// File: tb/tb_seg_planner.sv
module tb_seg_planner;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic [15:0] reqLen = '0;
  logic        reqNoBurst = 1'b0;
  logic        segValid;
  logic        segReady = 1'b0;
  logic        segBurst, segBounce, segLast;
  logic [31:0] segAddr;
  logic [15:0] segLen;

  always #4 clk = ~clk;

  seg_planner dut (.*);

  int testsRun = 0;
  int testsFailed = 0;
  int stallPhase = 0;

  logic [31:0] eAddr [256];
  logic [15:0] eLen  [256];
  logic        eBur  [256];
  logic        eBnc  [256];
  int          eN;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] a, input logic [15:0] l, input bit b, input bit bn);
    eAddr[eN] = a; eLen[eN] = l; eBur[eN] = b; eBnc[eN] = bn; eN++;
  endtask

  task automatic emitImm(input logic [31:0] a, input int n);
    logic [31:0] p = a;
    int r = n;
    while (r >= 4) begin push(p, 16'd4, 0, 0); p += 4; r -= 4; end
    if (r == 3) begin push(p, 16'd2, 0, 0); push(p + 2, 16'd1, 0, 0); end
    else if (r > 0) push(p, 16'(r), 0, 0);
  endtask

  task automatic buildExp(input logic [31:0] a, input int n, input bit nb);
    int hd, tl, md;
    eN = 0;
    if (n < 32 || nb) begin
      emitImm(a, n);
    end else begin
      hd = (32 - int'(a[4:0])) % 32;
      tl = (int'(a[4:0]) + n) % 32;
      md = n - hd - tl;
      if (md == 0) begin
        push(a, 16'd32, 1, 1);
        emitImm(a + 32, n - 32);
      end else begin
        emitImm(a, hd);
        push(a + 32'(hd), 16'(md), 1, 0);
        emitImm(a + 32'(hd + md), tl);
      end
    end
  endtask

  task automatic runReq(input logic [31:0] a, input int n, input bit nb, input string tag);
    int got = 0;
    bit done = 0;
    bit held = 0;
    bit busyOk = 1;
    int guard = 0;
    logic [31:0] hAddr; logic [15:0] hLen;
    buildExp(a, n, nb);
    @(negedge clk);
    reqAddr = a; reqLen = 16'(n); reqNoBurst = nb; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (!done && guard < 2000) begin
      guard++;
      segReady = ((stallPhase++ % 3) != 1);
      #1;
      if (segValid) begin
        if (reqReady) busyOk = 0;
        if (held) begin
          check(segAddr == hAddr && segLen == hLen, "R11", "stalled segment changed",
                {segAddr, 16'h0, segLen}, {hAddr, 16'h0, hLen});
          held = 0;
        end
        if (!segReady) begin held = 1; hAddr = segAddr; hLen = segLen; end
        else begin
          if (got >= eN) begin
            check(0, tag, "extra segment", 64'(got), 64'(eN));
            done = 1;
          end else begin
            check(segAddr == eAddr[got] && segLen == eLen[got] && segBurst == eBur[got]
                  && segBounce == eBnc[got] && segLast == (got == eN - 1),
                  {tag, " R7 R9"}, $sformatf("segment %0d addr/len/burst/bounce/last", got),
                  {segAddr, segLen, 13'h0, segBurst, segBounce, segLast},
                  {eAddr[got], eLen[got], 13'h0, eBur[got], eBnc[got], 1'(got == eN - 1)});
            if (segLast) done = 1;
            got++;
          end
        end
      end
      @(negedge clk);
    end
    segReady = 1'b0;
    check(got == eN, tag, "segment count", 64'(got), 64'(eN));
    check(busyOk, "R10", "reqReady high while segments pending", 64'(busyOk), 64'd1);
    #1;
    check(reqReady && !segValid, "R10", "idle after last segment",
          {62'h0, reqReady, segValid}, 64'h2);
  endtask

  task automatic runZero();
    @(negedge clk);
    reqAddr = 32'h44; reqLen = 16'd0; reqNoBurst = 1'b0; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    #1;
    check(!segValid && reqReady, "R8", "zero-length produced segment or stalled",
          {62'h0, reqReady, segValid}, 64'h2);
    @(negedge clk); #1;
    check(!segValid, "R8", "late segment after zero-length", 64'(segValid), 64'd0);
  endtask

  task automatic runReset();
    #1;
    check(!segValid && reqReady, "R1", "reset state", {62'h0, reqReady, segValid}, 64'h2);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    runReset();
    rstN = 1'b1;
    @(negedge clk);
    runReset();
    runReq(32'h0000_0100, 20, 0, "R2");             // short request, 4-byte pieces
    runReq(32'h0000_0203, 70, 1, "R2");             // burst barred
    runReq(32'h0000_0010, 7, 0, "R3");              // 4,2,1
    runReq(32'h0000_0011, 3, 0, "R3");              // 2,1
    runReq(32'h0000_0013, 6, 0, "R3");              // 4,2
    runReq(32'h0000_0015, 1, 0, "R3");              // single byte
    runReq(32'h0000_1005, 100, 0, "R4 R5");         // head 27, mid 64, tail 9
    runReq(32'h0000_2000, 64, 0, "R4");             // fully aligned, one burst
    runReq(32'h0000_2008, 56, 0, "R5");             // head 24, mid 32, no tail
    runReq(32'h0000_3011, 40, 0, "R6");             // bounce then 8 bytes
    runReq(32'h0000_0005, 32, 0, "R6");             // bounce only
    runReq(32'h0000_4001, 62, 0, "R6");             // bounce then 30 bytes
    runZero();
    runReq(32'hFFFF_FFF0, 64, 0, "R12");            // wraps through zero
    runReq(32'hFFFF_FFFE, 5, 0, "R12");             // immediate wrap
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule